// File: doc/BRIEF.md
# NAND Read-Retry Parameter Sequencer

This block puts a multi-level-cell NAND device into a chosen read-retry mode. After a start request it walks the device through a private programming sequence on a raw cycle interface. First one command cycle opens the device's parameter-set mode. Then, for each retry register, it sends an address cycle followed by a data-out cycle. The sequence closes with a second command cycle that commits the new settings. A host controller calls it whenever a page read fails ECC and a different retry mode is to be tried.

The register addresses come from a fixed table inside the block. The per-mode values come from a flattened value table presented on an input port. The block picks the value for register `i` in mode `m` at table offset `m*count + i`. Every cycle request is held on the interface until the NAND cycle engine accepts it with `cyc_ready`. The engine can report a failed cycle with `cyc_fail` in the same clock. The block reports the outcome with a one-clock `done` pulse or a sticky `err` flag.

Top module: `nand_retry_seq`

## Requirements
- R1: A `start` seen while `busy` is low is accepted, and `mode` and `reg_count` are sampled then. In the next cycle `cyc_valid` is high with a command cycle (`cyc_kind` = 0) carrying byte 0x36.
- R2: After the enter command, each register index i from 0 to count-1 produces one address cycle (`cyc_kind` = 1) carrying address table entry i, then one data-out cycle (`cyc_kind` = 2). The address table for indices 0..7 is 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF.
- R3: The data byte for register i in mode m is `val_table[8*(m*count+i) +: 8]`.
- R4: After the last register (or after the enter command when count is zero) one command cycle carrying 0x16 is issued. When it is accepted without failure, `done` is high in the following cycle and `busy` goes low.
- R5: A register count of zero yields exactly two cycles: the enter command and the apply command.
- R6: A `reg_count` above MAX_REGS (8) is treated as MAX_REGS, both for the number of registers and in the offset product.
- R7: If a cycle is accepted with `cyc_fail` high, the sequence aborts. In the next cycle `cyc_valid` and `busy` are low, `err` is high and `done` stays low, and no apply command is issued.
- R8: `err` is low after reset. It stays high until the next accepted start and is cleared in the cycle after that start.
- R9: A `start` while `busy` is high has no effect on the running sequence or on its sampled mode and count.
- R10: While `cyc_valid` is high and `cyc_ready` is low, `cyc_kind` and `cyc_byte` hold their values into the next cycle.
- R11: `done` is high for exactly one clock per completed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to program a retry mode |
| mode | input | 3 | Retry-mode index, sampled on an accepted start |
| reg_count | input | 4 | Number of retry registers, sampled on an accepted start |
| val_table | input | 512 | Flattened per-mode value bytes, entry k in bits 8k+7..8k |
| cyc_valid | output | 1 | A cycle request is presented |
| cyc_ready | input | 1 | Cycle engine accepts the presented request |
| cyc_fail | input | 1 | Accepted cycle failed (meaningful with cyc_ready) |
| cyc_kind | output | 2 | 0 command, 1 address, 2 data-out |
| cyc_byte | output | 8 | Byte carried by the cycle |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-clock pulse on successful completion |
| err | output | 1 | Sticky abort flag, cleared by the next accepted start |

## Verification
The bound checker watches, on every cycle, the properties that are local in time. These are the enter command after an accepted start, request stability under back-pressure, the abort response to a failed cycle, the single-clock width of `done`, the link from `done` back to an accepted apply command, and the persistence of `err`. The full order of addresses and values cannot be seen that way: that the right table entry appears for each register and mode, the count saturation, the zero-count path and the immunity to a start while busy. Only the bench shows these, by matching every presented cycle against an expected list built from the mode and count.

// File: rtl/nrr_pkg.sv
package nrr_pkg;

    typedef enum logic [1:0] {
        CYC_CMD  = 2'd0,
        CYC_ADDR = 2'd1,
        CYC_DATA = 2'd2
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_ADDR,
        ST_DATA,
        ST_APPLY
    } seq_state_e;

    typedef struct packed {
        cyc_kind_e  kind;
        logic [7:0] data;
    } cyc_req_t;

    localparam logic [7:0] OP_ENTER = 8'h36;
    localparam logic [7:0] OP_APPLY = 8'h16;

    // Retry register addresses of the 1x-nm family; beyond index 7 unused.
    function automatic logic [7:0] retry_reg_addr(input int unsigned idx);
        logic [7:0] a;
        case (idx)
            0:       a = 8'hCC;
            1:       a = 8'hBF;
            2:       a = 8'hAA;
            3:       a = 8'hAB;
            4:       a = 8'hCD;
            5:       a = 8'hAD;
            6:       a = 8'hAE;
            7:       a = 8'hAF;
            default: a = 8'h00;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/nrr_ctrl.sv
module nrr_ctrl
    import nrr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       cyc_ready,
    input  logic       cyc_fail,
    input  logic       cnt_zero,
    input  logic       last_idx,
    output seq_state_e state,
    output logic       accept,
    output logic       idx_inc,
    output logic       done,
    output logic       err
);

    seq_state_e state_q, state_d;
    logic       done_q, err_q;
    logic       hs_ok, hs_bad;

    assign hs_ok  = (state_q != ST_IDLE) && cyc_ready && !cyc_fail;
    assign hs_bad = (state_q != ST_IDLE) && cyc_ready && cyc_fail;
    assign accept = (state_q == ST_IDLE) && start;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ENTER;
            ST_ENTER: begin
                if (hs_bad)     state_d = ST_IDLE;
                else if (hs_ok) state_d = cnt_zero ? ST_APPLY : ST_ADDR;
            end
            ST_ADDR: begin
                if (hs_bad)     state_d = ST_IDLE;
                else if (hs_ok) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (hs_bad)     state_d = ST_IDLE;
                else if (hs_ok) state_d = last_idx ? ST_APPLY : ST_ADDR;
            end
            ST_APPLY: if (hs_bad || hs_ok) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign idx_inc = (state_q == ST_DATA) && hs_ok && !last_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_APPLY) && hs_ok;
            if (accept)      err_q <= 1'b0;
            else if (hs_bad) err_q <= 1'b1;
        end
    end

    assign state = state_q;
    assign done  = done_q;
    assign err   = err_q;

endmodule

// File: rtl/nrr_ptr.sv
module nrr_ptr #(
    parameter int NUM_MODES = 8,
    parameter int MAX_REGS  = 8,
    localparam int MODE_W   = $clog2(NUM_MODES),
    localparam int CNT_W    = $clog2(MAX_REGS + 1),
    localparam int IDX_W    = $clog2(MAX_REGS),
    localparam int OFS_W    = $clog2(NUM_MODES * MAX_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [MODE_W-1:0] mode_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              idx_inc,
    output logic [IDX_W-1:0]  idx,
    output logic [OFS_W-1:0]  ofs,
    output logic              cnt_zero,
    output logic              last_idx
);

    localparam int PROD_W = MODE_W + CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_REGS);

    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  cnt_q, cnt_sat;
    logic [IDX_W-1:0]  idx_q;
    logic [PROD_W-1:0] ofs_full;

    assign cnt_sat = (count_in > CNT_MAX) ? CNT_MAX : count_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
        end else if (accept) begin
            mode_q <= mode_in;
            cnt_q  <= cnt_sat;
            idx_q  <= '0;
        end else if (idx_inc) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign ofs_full = PROD_W'(mode_q) * PROD_W'(cnt_q) + PROD_W'(idx_q);
    assign ofs      = OFS_W'(ofs_full);
    assign idx      = idx_q;
    assign cnt_zero = (cnt_q == '0);
    assign last_idx = ((CNT_W'(idx_q) + 1'b1) == cnt_q);

endmodule

// File: rtl/nrr_emit.sv
module nrr_emit
    import nrr_pkg::*;
#(
    parameter int NUM_MODES = 8,
    parameter int MAX_REGS  = 8,
    localparam int IDX_W    = $clog2(MAX_REGS),
    localparam int OFS_W    = $clog2(NUM_MODES * MAX_REGS),
    localparam int ENTRIES  = NUM_MODES * MAX_REGS
) (
    input  seq_state_e            state,
    input  logic [IDX_W-1:0]      idx,
    input  logic [OFS_W-1:0]      ofs,
    input  logic [8*ENTRIES-1:0]  val_table,
    output cyc_req_t              req
);

    logic [7:0] addr_tab [MAX_REGS];
    logic [7:0] val_arr  [ENTRIES];

    for (genvar g = 0; g < MAX_REGS; g++) begin : g_addr
        assign addr_tab[g] = retry_reg_addr(g);
    end

    for (genvar k = 0; k < ENTRIES; k++) begin : g_val
        assign val_arr[k] = val_table[8*k +: 8];
    end

    always_comb begin
        req.kind = CYC_CMD;
        req.data = 8'h00;
        case (state)
            ST_ENTER: begin
                req.kind = CYC_CMD;
                req.data = OP_ENTER;
            end
            ST_ADDR: begin
                req.kind = CYC_ADDR;
                req.data = addr_tab[idx];
            end
            ST_DATA: begin
                req.kind = CYC_DATA;
                req.data = val_arr[ofs];
            end
            ST_APPLY: begin
                req.kind = CYC_CMD;
                req.data = OP_APPLY;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nand_retry_seq.sv
module nand_retry_seq
    import nrr_pkg::*;
#(
    parameter int NUM_MODES = 8,
    parameter int MAX_REGS  = 8,
    localparam int MODE_W   = $clog2(NUM_MODES),
    localparam int CNT_W    = $clog2(MAX_REGS + 1),
    localparam int IDX_W    = $clog2(MAX_REGS),
    localparam int OFS_W    = $clog2(NUM_MODES * MAX_REGS),
    localparam int TAB_W    = 8 * NUM_MODES * MAX_REGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [CNT_W-1:0]  reg_count,
    input  logic [TAB_W-1:0]  val_table,
    output logic              cyc_valid,
    input  logic              cyc_ready,
    input  logic              cyc_fail,
    output logic [1:0]        cyc_kind,
    output logic [7:0]        cyc_byte,
    output logic              busy,
    output logic              done,
    output logic              err
);

    seq_state_e       state;
    logic             accept, idx_inc, cnt_zero, last_idx;
    logic [IDX_W-1:0] idx;
    logic [OFS_W-1:0] ofs;
    cyc_req_t         req;

    nrr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cyc_ready (cyc_ready),
        .cyc_fail  (cyc_fail),
        .cnt_zero  (cnt_zero),
        .last_idx  (last_idx),
        .state     (state),
        .accept    (accept),
        .idx_inc   (idx_inc),
        .done      (done),
        .err       (err)
    );

    nrr_ptr #(
        .NUM_MODES (NUM_MODES),
        .MAX_REGS  (MAX_REGS)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .mode_in  (mode),
        .count_in (reg_count),
        .idx_inc  (idx_inc),
        .idx      (idx),
        .ofs      (ofs),
        .cnt_zero (cnt_zero),
        .last_idx (last_idx)
    );

    nrr_emit #(
        .NUM_MODES (NUM_MODES),
        .MAX_REGS  (MAX_REGS)
    ) u_emit (
        .state     (state),
        .idx       (idx),
        .ofs       (ofs),
        .val_table (val_table),
        .req       (req)
    );

    assign cyc_valid = (state != ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign cyc_kind  = req.kind;
    assign cyc_byte  = req.data;

endmodule

// File: rtl/nrr_checker.sv
module nrr_checker (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       cyc_valid,
    input logic       cyc_ready,
    input logic       cyc_fail,
    input logic [1:0] cyc_kind,
    input logic [7:0] cyc_byte,
    input logic       done,
    input logic       err
);

    assert_enter_first_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (cyc_valid && cyc_kind == 2'd0 && cyc_byte == 8'h36));

    assert_done_after_apply_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(cyc_valid && cyc_ready && !cyc_fail
                              && cyc_kind == 2'd0 && cyc_byte == 8'h16));

    assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_ready && cyc_fail) |=> (!cyc_valid && err && !done));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err && !(start && !busy)) |=> err);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && !cyc_ready) |=> (cyc_valid && $stable(cyc_kind) && $stable(cyc_byte)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind nand_retry_seq nrr_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .cyc_valid (cyc_valid),
    .cyc_ready (cyc_ready),
    .cyc_fail  (cyc_fail),
    .cyc_kind  (cyc_kind),
    .cyc_byte  (cyc_byte),
    .done      (done),
    .err       (err)
);

// File: tb/test_nand_retry_seq.sv
`timescale 1ns/100ps
module test_nand_retry_seq;

    localparam int NM  = 8;
    localparam int MR  = 8;
    localparam int TBW = 8 * NM * MR;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [2:0]     mode = '0;
    logic [3:0]     reg_count = '0;
    logic [TBW-1:0] val_table;
    logic           cyc_valid, cyc_ready = 1'b0, cyc_fail = 1'b0;
    logic [1:0]     cyc_kind;
    logic [7:0]     cyc_byte;
    logic           busy, done, err;

    always #2.5 clk = ~clk;

    nand_retry_seq i_nand_retry_seq (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .reg_count(reg_count),
        .val_table(val_table), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
        .cyc_fail(cyc_fail), .cyc_kind(cyc_kind), .cyc_byte(cyc_byte),
        .busy(busy), .done(done), .err(err)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] addr_ref [8] = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};

    logic [9:0] exp_q [$];
    bit m_busy = 0, m_done = 0, m_err = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [7:0] tab_val(int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    initial begin
        for (int k = 0; k < NM * MR; k++) val_table[8*k +: 8] = tab_val(k);
    end

    function automatic void build(int md, int cnt);
        int c = (cnt > MR) ? MR : cnt;
        exp_q.delete();
        exp_q.push_back({2'd0, 8'h36});
        for (int i = 0; i < c; i++) begin
            exp_q.push_back({2'd1, addr_ref[i]});
            exp_q.push_back({2'd2, tab_val(md * c + i)});
        end
        exp_q.push_back({2'd0, 8'h16});
    endfunction

    task automatic tick(bit s, int md, int cnt, bit rdy, bit f, string tag);
        bit bad;
        @(negedge clk);
        start = s; mode = 3'(md); reg_count = 4'(cnt); cyc_ready = rdy; cyc_fail = f;
        #0.5;
        checks++;
        bad = (cyc_valid !== m_busy) || (busy !== m_busy) || (done !== m_done) || (err !== m_err);
        if (m_busy && exp_q.size() > 0)
            bad = bad || ({cyc_kind, cyc_byte} !== exp_q[0]);
        if (bad) begin
            fails++;
            $display("FAIL %s: got valid=%b busy=%b done=%b err=%b kind=%0d byte=%02h, expected valid=%b busy=%b done=%b err=%b cyc=%03h",
                     tag, cyc_valid, busy, done, err, cyc_kind, cyc_byte,
                     m_busy, m_busy, m_done, m_err, (exp_q.size() > 0) ? exp_q[0] : 10'h0);
        end
        @(posedge clk);
        if (!m_busy) begin
            m_done = 0;
            if (s) begin build(md, cnt); m_busy = 1; m_err = 0; end
        end else if (rdy) begin
            if (f) begin
                m_busy = 0; m_err = 1; m_done = 0; exp_q.delete();
            end else begin
                void'(exp_q.pop_front());
                if (exp_q.size() == 0) begin m_busy = 0; m_done = 1; end
                else m_done = 0;
            end
        end else begin
            m_done = 0;
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // fail_at < 0: no failure injected; busy_md >= 0: start with that mode while busy
    task automatic run_seq(int md, int cnt, bit stall, int fail_at, int busy_md, string tag);
        int n = 0;
        tick(1'b1, md, cnt, 1'b0, 1'b0, tag);
        while (m_busy) begin
            bit rdy = stall ? lfsr[0] : 1'b1;
            bit f   = rdy && (n == fail_at);
            bit s   = (busy_md >= 0) && (n == 2);
            tick(s, (busy_md >= 0) ? busy_md : md, (busy_md >= 0) ? 5 : cnt, rdy, f, tag);
            if (rdy) n++;
        end
        tick(1'b0, 0, 0, 1'b0, 1'b0, tag);
        tick(1'b0, 0, 0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(5ns * 20000);
        fails++;
        $display("FAIL watchdog: got no completion, expected end of run");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        tick(1'b0, 0, 0, 1'b0, 1'b0, "R8 reset state");
        tick(1'b0, 0, 0, 1'b1, 1'b0, "R8 idle with ready");
        run_seq(0, 8, 1'b0, -1, -1, "R1 R2 R3 R4 R11 mode0 full");
        run_seq(5, 3, 1'b1, -1, -1, "R3 R10 mode5 count3 stalled");
        run_seq(2, 0, 1'b1, -1, -1, "R5 zero count");
        run_seq(7, 12, 1'b0, -1, -1, "R6 count saturation");
        run_seq(3, 4, 1'b1, 4, -1, "R7 fail on data");
        tick(1'b0, 0, 0, 1'b1, 1'b1, "R8 err held");
        tick(1'b0, 0, 0, 1'b0, 1'b0, "R8 err held");
        run_seq(1, 2, 1'b0, 0, -1, "R7 fail on enter");
        run_seq(4, 6, 1'b1, -1, 6, "R9 R8 start while busy");
        run_seq(6, 1, 1'b0, 3, -1, "R7 fail on apply");
        run_seq(6, 8, 1'b1, -1, -1, "R2 R3 mode6 full stalled");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule